// File: doc/BRIEF.md
# Serial Key Unlocked Register Port

This block sits beside a memory on a shared bus and watches the bus chip enable, output enable, write enable and a one-bit data line. It claims no address space of its own. Until a 64-bit unlock key has been written one bit per write cycle, every access is passed straight through to the memory's chip enable. Once the whole key has matched, the block takes the next 64 bus cycles for itself. It shifts eight 8-bit timekeeping registers out on a serial data output during reads, or in from the data line during writes. The memory stays disabled for those 64 cycles.

The bus inputs are sampled synchronously and pass through a synchroniser. A bus cycle counts when the chip enable input deasserts. Only the synchronised copies are used to detect that edge. The register file outside the block supplies a parallel image of the eight registers, which is captured when the key completes. Written bytes are returned through a commit strobe carrying the register index and the byte. A power-fail input and an external reset pin can abort a transfer. A bit inside the register image sets whether the reset pin is obeyed.

Top module: `serial_key_port`

## Requirements
- R1: After reset, recognition is disarmed. `mem_ce_n_o` follows `ce_n_i`, `q_oe_o` is 0 and `commit_o` is 0.
- R2: A bus cycle is a read when `oe_n_i` is low and `we_n_i` is high during it, and a write when `we_n_i` is low. It takes effect when `ce_n_i` rises. A read arms recognition and sets the key pointer to key bit 0. A write while armed compares `d_i` with the key bit at the pointer.
- R3: The key is bytes 0xC5, 0x3A, 0xA3, 0x5C, 0xC5, 0x3A, 0xA3, 0x5C. Bytes are taken in that order and each byte is compared LSB first. Writes made before any arming read never unlock the port.
- R4: On a mismatching write bit the pointer stays put and recognition disarms. Later writes are ignored until a read re-arms it. A read part-way through the key restarts the comparison at bit 0.
- R5: Before unlock, `mem_ce_n_o` equals `ce_n_i`. From the full key match until 64 transfer cycles have completed, `mem_ce_n_o` is held at 1. Afterwards forwarding resumes and recognition is disarmed.
- R6: In each transfer cycle, a read drives one bit on `q_o` with `q_oe_o`=1 while chip enable and output enable are low. A write takes in one bit from `d_i`. `q_oe_o` is 0 outside read transfer cycles.
- R7: Transfer bit n (0..63) is bit n%8 of register n/8. Register r occupies `reg_img_i[8r+7:8r]`, which is captured when the key completes.
- R8: During a write transfer, a register's byte is emitted on `commit_data_o`, together with `commit_idx_o` and a one-cycle `commit_o`, only once all 8 of its bits have arrived.
- R9: Cycles in which `ce_n_i` stays high, whatever `oe_n_i` and `we_n_i` do, disturb neither recognition nor transfer.
- R10: While `pwr_fail_i` is 1, `mem_ce_n_o` is 1 and any recognition or transfer is aborted with no further commits. Once power returns the port is locked and disarmed.
- R11: When `reg_img_i[36]` (reset-ignore bit) is 0, a low on `ext_rst_ni` aborts the transfer without commits. When that bit is 1, `ext_rst_ni` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_n_i | input | 1 | Bus chip enable, active low |
| oe_n_i | input | 1 | Bus output enable, active low |
| we_n_i | input | 1 | Bus write enable, active low |
| d_i | input | 1 | Serial data in |
| pwr_fail_i | input | 1 | Power-fail indication |
| ext_rst_ni | input | 1 | External abort pin, active low |
| reg_img_i | input | 64 | Parallel image of the eight registers |
| mem_ce_n_o | output | 1 | Chip enable to external memory |
| q_o | output | 1 | Serial data out |
| q_oe_o | output | 1 | Output enable for q_o |
| commit_o | output | 1 | Byte commit strobe |
| commit_idx_o | output | 3 | Index of the committed register |
| commit_data_o | output | 8 | Committed byte |

## Verification
The bench sends keys that break at a random bit and then carry on correctly. A design that let the pointer move on after a mismatch would unlock here. It sends a key with no arming read, and one cut by a read half-way. A design that kept the pointer through the read would fail the full key that follows. It interleaves write and read strobes with chip enable held high. A design that counted those strobes would mis-step the key or the transfer. It aborts a write transfer part-way by power-fail and by the reset pin, with the reset-ignore bit set both ways. Extra or early commits, or a memory enable left blocked after the abort, are caught at the ports.

// File: rtl/skp_pkg.sv
package skp_pkg;
  typedef struct packed {
    logic rd;
    logic wr;
    logic d;
  } skp_ev_t;
endpackage

// File: rtl/skp_sync.sv
module skp_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] in_i,
  input  logic [W-1:0] rst_val_i,
  output logic [W-1:0] out_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= rst_val_i;
      else if (s == 0) stg[s] <= in_i;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign out_o = stg[STAGES-1];
endmodule

// File: rtl/skp_cycle_dec.sv
module skp_cycle_dec
  import skp_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    ce_n_s_i,
  input  logic    oe_n_s_i,
  input  logic    we_n_s_i,
  input  logic    d_s_i,
  output skp_ev_t ev_o
);
  logic ce_p, oe_p, we_p, d_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_p <= 1'b1;
      oe_p <= 1'b1;
      we_p <= 1'b1;
      d_p  <= 1'b0;
    end else begin
      ce_p <= ce_n_s_i;
      oe_p <= oe_n_s_i;
      we_p <= we_n_s_i;
      d_p  <= d_s_i;
    end
  end

  // cycle ends on deasserting edge of chip enable; attributes from last low sample
  logic fin;
  assign fin     = ce_n_s_i && !ce_p;
  assign ev_o.wr = fin && !we_p;
  assign ev_o.rd = fin && we_p && !oe_p;
  assign ev_o.d  = d_p;
endmodule

// File: rtl/skp_key_match.sv
module skp_key_match
  import skp_pkg::*;
#(
  parameter int          KEY_BITS = 64,
  parameter logic [63:0] KEY_WORD = 64'h5CA3_3AC5_5CA3_3AC5,
  localparam int         PTR_W    = $clog2(KEY_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             abort_i,
  input  skp_ev_t          ev_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             hit_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(KEY_BITS - 1);

  logic [PTR_W-1:0] ptr_q;
  logic             dead_q;
  logic             bit_ok;

  assign bit_ok = (ev_i.d == KEY_WORD[ptr_q]);
  assign hit_o  = en_i && !abort_i && ev_i.wr && !dead_q && bit_ok && (ptr_q == LAST);
  assign ptr_o  = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      dead_q <= 1'b1;
    end else if (abort_i) begin
      ptr_q  <= '0;
      dead_q <= 1'b1;
    end else if (en_i) begin
      if (ev_i.rd) begin
        ptr_q  <= '0;
        dead_q <= 1'b0;
      end else if (ev_i.wr && !dead_q) begin
        if (!bit_ok) begin
          dead_q <= 1'b1;
        end else if (ptr_q == LAST) begin
          ptr_q  <= '0;
          dead_q <= 1'b1;
        end else begin
          ptr_q <= ptr_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/skp_xfer.sv
module skp_xfer
  import skp_pkg::*;
#(
  parameter int  REG_BYTES = 8,
  parameter int  BYTE_W    = 8,
  localparam int XFER_BITS = REG_BYTES * BYTE_W,
  localparam int CNT_W     = $clog2(XFER_BITS),
  localparam int BIT_W     = $clog2(BYTE_W),
  localparam int IDX_W     = $clog2(REG_BYTES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 abort_i,
  input  skp_ev_t              ev_i,
  input  logic [XFER_BITS-1:0] snap_i,
  output logic                 active_o,
  output logic                 q_o,
  output logic                 commit_o,
  output logic [IDX_W-1:0]     commit_idx_o,
  output logic [BYTE_W-1:0]    commit_data_o
);
  localparam logic [CNT_W-1:0] LAST     = CNT_W'(XFER_BITS - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

  logic                 active_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [XFER_BITS-1:0] snap_q;
  logic [BYTE_W-1:0]    wbuf_q, wbuf_nx;
  logic [BIT_W-1:0]     bit_idx;

  assign bit_idx = cnt_q[BIT_W-1:0];

  always_comb begin
    wbuf_nx          = wbuf_q;
    wbuf_nx[bit_idx] = ev_i.d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q      <= 1'b0;
      cnt_q         <= '0;
      snap_q        <= '0;
      wbuf_q        <= '0;
      commit_o      <= 1'b0;
      commit_idx_o  <= '0;
      commit_data_o <= '0;
    end else begin
      commit_o <= 1'b0;
      if (abort_i) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else if (start_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        snap_q   <= snap_i;
      end else if (active_q && (ev_i.rd || ev_i.wr)) begin
        if (ev_i.wr) begin
          wbuf_q <= wbuf_nx;
          if (bit_idx == BIT_LAST) begin
            commit_o      <= 1'b1;
            commit_idx_o  <= cnt_q[CNT_W-1:BIT_W];
            commit_data_o <= wbuf_nx;
          end
        end
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) active_q <= 1'b0;
      end
    end
  end

  assign active_o = active_q;
  assign q_o      = snap_q[cnt_q];
endmodule

// File: rtl/serial_key_port.sv
module serial_key_port
  import skp_pkg::*;
#(
  parameter int          REG_BYTES   = 8,
  parameter int          BYTE_W      = 8,
  parameter int          SYNC_STAGES = 2,
  parameter int          RST_IGN_BIT = 36,
  parameter logic [63:0] KEY_WORD    = 64'h5CA3_3AC5_5CA3_3AC5,
  localparam int         XFER_BITS   = REG_BYTES * BYTE_W,
  localparam int         IDX_W       = $clog2(REG_BYTES),
  localparam int         PTR_W       = $clog2(64)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ce_n_i,
  input  logic                 oe_n_i,
  input  logic                 we_n_i,
  input  logic                 d_i,
  input  logic                 pwr_fail_i,
  input  logic                 ext_rst_ni,
  input  logic [XFER_BITS-1:0] reg_img_i,
  output logic                 mem_ce_n_o,
  output logic                 q_o,
  output logic                 q_oe_o,
  output logic                 commit_o,
  output logic [IDX_W-1:0]     commit_idx_o,
  output logic [BYTE_W-1:0]    commit_data_o
);
  logic [3:0]       bus_s;
  skp_ev_t          ev;
  logic             active, hit, abort;
  logic [PTR_W-1:0] ptr;

  skp_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .in_i      ({ce_n_i, oe_n_i, we_n_i, d_i}),
    .rst_val_i (4'b1110),
    .out_o     (bus_s)
  );

  skp_cycle_dec u_dec (
    .clk_i, .rst_ni,
    .ce_n_s_i (bus_s[3]),
    .oe_n_s_i (bus_s[2]),
    .we_n_s_i (bus_s[1]),
    .d_s_i    (bus_s[0]),
    .ev_o     (ev)
  );

  assign abort = pwr_fail_i || (!ext_rst_ni && !reg_img_i[RST_IGN_BIT]);

  skp_key_match #(.KEY_BITS(64), .KEY_WORD(KEY_WORD)) u_match (
    .clk_i, .rst_ni,
    .en_i    (!active),
    .abort_i (abort),
    .ev_i    (ev),
    .ptr_o   (ptr),
    .hit_o   (hit)
  );

  skp_xfer #(.REG_BYTES(REG_BYTES), .BYTE_W(BYTE_W)) u_xfer (
    .clk_i, .rst_ni,
    .start_i       (hit),
    .abort_i       (abort),
    .ev_i          (ev),
    .snap_i        (reg_img_i),
    .active_o      (active),
    .q_o           (q_o),
    .commit_o      (commit_o),
    .commit_idx_o  (commit_idx_o),
    .commit_data_o (commit_data_o)
  );

  assign q_oe_o     = active && !pwr_fail_i && !bus_s[3] && !bus_s[2] && bus_s[1];
  assign mem_ce_n_o = pwr_fail_i || active || ce_n_i;
endmodule

// File: rtl/serial_key_port_chk.sv
module serial_key_port_chk #(
  parameter int RST_IGN_BIT = 36
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        active,
  input logic [5:0]  ptr,
  input logic        pwr_fail_i,
  input logic        ext_rst_ni,
  input logic [63:0] reg_img_i,
  input logic        mem_ce_n_o,
  input logic        q_oe_o,
  input logic        commit_o
);
  // R2
  enter_on_full_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active) |-> $past(ptr) == 6'd63);
  // R8
  commit_in_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(active));
  // R10
  pwr_stops_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_fail_i |=> !active);
  // R5
  mem_blocked_on_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_oe_o |-> mem_ce_n_o);
  // R11
  ext_rst_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_rst_ni && !reg_img_i[RST_IGN_BIT]) |=> !active);
endmodule

bind serial_key_port serial_key_port_chk #(.RST_IGN_BIT(RST_IGN_BIT)) u_chk (
  .clk_i, .rst_ni,
  .active     (active),
  .ptr        (ptr),
  .pwr_fail_i, .ext_rst_ni, .reg_img_i,
  .mem_ce_n_o, .q_oe_o, .commit_o
);

// File: tb/serial_key_port_bench.sv
module serial_key_port_bench;
  logic clk = 0, rst_n = 0;
  logic ce_n = 1, oe_n = 1, we_n = 1, d = 0, pwr_fail = 0, ext_rst_n = 1;
  logic [63:0] reg_img = '0;
  logic mem_ce_n, q, q_oe, commit;
  logic [2:0] commit_idx;
  logic [7:0] commit_data;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  serial_key_port u_serial_key_port (
    .clk_i(clk), .rst_ni(rst_n), .ce_n_i(ce_n), .oe_n_i(oe_n), .we_n_i(we_n),
    .d_i(d), .pwr_fail_i(pwr_fail), .ext_rst_ni(ext_rst_n), .reg_img_i(reg_img),
    .mem_ce_n_o(mem_ce_n), .q_o(q), .q_oe_o(q_oe), .commit_o(commit),
    .commit_idx_o(commit_idx), .commit_data_o(commit_data));

  int n_commit = 0;
  logic [7:0] got_data [8];
  logic [2:0] got_idx [8];
  always @(negedge clk) if (commit) begin
    if (n_commit < 8) begin
      got_data[n_commit] = commit_data;
      got_idx[n_commit]  = commit_idx;
    end
    n_commit++;
  end

  function automatic bit key_bit(int i);
    logic [7:0] kb [4] = '{8'hC5, 8'h3A, 8'hA3, 8'h5C};
    return kb[(i / 8) % 4][i % 8];
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  bit last_q, last_qoe, last_mce;
  task automatic bus(bit rd, bit wr, bit dv);
    @(negedge clk);
    ce_n = 0; oe_n = !rd; we_n = !wr; d = dv;
    #1 last_mce = mem_ce_n;
    repeat (4) @(negedge clk);
    last_q = q; last_qoe = q_oe;
    ce_n = 1;
    @(negedge clk);
    oe_n = 1; we_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic other_mem(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); we_n = 0; d = ~d;
      @(negedge clk); we_n = 1; oe_n = 0;
      @(negedge clk); oe_n = 1;
    end
  endtask

  task automatic send_key(int from, int to);
    for (int i = from; i < to; i++) bus(0, 1, key_bit(i));
  endtask

  // probe: a neutral cycle reveals whether memory is forwarded
  task automatic probe(bit exp_mce, string req);
    bus(0, 0, 0);
    chk(last_mce == exp_mce, req, last_mce, exp_mce);
  endtask

  task automatic read_all(logic [63:0] img, string req);
    int bad = 0;
    for (int i = 0; i < 64; i++) begin
      bus(1, 0, 0);
      if (last_q !== img[i] || last_qoe !== 1'b1 || last_mce !== 1'b1) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] img, wdata;
    int bad, pos;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(q_oe == 0 && commit == 0 && mem_ce_n == 1, "R1 idle", {q_oe, commit, mem_ce_n}, 3'b001);
    rst_n = 1;
    @(negedge clk);
    probe(0, "R1 forward after reset");

    // R3 key without arming read never unlocks
    send_key(0, 64);
    probe(0, "R3 unarmed key");

    // R2 R3 R5 R6 R7 full unlock and read transfer, random images
    for (int t = 0; t < 3; t++) begin
      img = {$urandom, $urandom};
      img[36] = 0;
      reg_img = img;
      bus(1, 0, 0);
      send_key(0, 64);
      chk(q_oe == 0, "R6 no drive idle", q_oe, 0);
      read_all(img, "R7 read bits order");
      probe(0, "R5 forward after transfer");
    end

    // R4 mismatch at random position, rest correct
    for (int t = 0; t < 3; t++) begin
      pos = $urandom_range(0, 63);
      bus(1, 0, 0);
      send_key(0, pos);
      bus(0, 1, !key_bit(pos));
      send_key(pos + 1, 64);
      probe(0, "R4 mismatch stays locked");
    end

    // R4 read mid-key restarts comparison
    bus(1, 0, 0);
    send_key(0, 30);
    bus(1, 0, 0);
    send_key(0, 64);
    probe(1, "R4 rearm after partial");
    read_all(reg_img, "R6 read after rearm");

    // R9 interleaved foreign cycles during key and transfer
    img = {$urandom, $urandom}; img[36] = 0; reg_img = img;
    bus(1, 0, 0);
    send_key(0, 32);
    other_mem(5);
    send_key(32, 64);
    other_mem(3);
    bad = 0;
    for (int i = 0; i < 64; i++) begin
      bus(1, 0, 0);
      if (last_q !== img[i]) bad++;
      if (i == 20) other_mem(4);
    end
    chk(bad == 0, "R9 interleave", bad, 0);

    // R8 write transfer commits
    for (int t = 0; t < 2; t++) begin
      wdata = {$urandom, $urandom};
      bus(1, 0, 0);
      send_key(0, 64);
      n_commit = 0;
      bad = 0;
      for (int i = 0; i < 64; i++) begin
        bus(0, 1, wdata[i]);
        if (n_commit != (i + 1) / 8) bad++;
      end
      chk(bad == 0, "R8 commit only at full byte", bad, 0);
      bad = 0;
      for (int k = 0; k < 8; k++)
        if (got_idx[k] !== 3'(k) || got_data[k] !== wdata[8*k +: 8]) bad++;
      chk(bad == 0 && n_commit == 8, "R8 commit data", n_commit, 8);
    end

    // R10 power fail mid write transfer
    wdata = {$urandom, $urandom};
    bus(1, 0, 0);
    send_key(0, 64);
    n_commit = 0;
    for (int i = 0; i < 20; i++) bus(0, 1, wdata[i]);
    @(negedge clk); pwr_fail = 1;
    @(negedge clk); ce_n = 0;
    #1 chk(mem_ce_n == 1, "R10 mem blocked", mem_ce_n, 1);
    @(negedge clk); ce_n = 1;
    for (int i = 20; i < 40; i++) bus(0, 1, wdata[i]);
    chk(n_commit == 2, "R10 no commits after fail", n_commit, 2);
    @(negedge clk); pwr_fail = 0;
    probe(0, "R10 locked after power back");

    // R11 reset pin obeyed when ignore bit is 0
    reg_img[36] = 0;
    bus(1, 0, 0);
    send_key(0, 64);
    n_commit = 0;
    for (int i = 0; i < 5; i++) bus(0, 1, 1);
    @(negedge clk); ext_rst_n = 0;
    @(negedge clk); ext_rst_n = 1;
    for (int i = 5; i < 8; i++) bus(0, 1, 1);
    chk(n_commit == 0, "R11 abort no commit", n_commit, 0);
    probe(0, "R11 abort forwards");

    // R11 reset pin ignored when ignore bit is 1
    img = {$urandom, $urandom}; img[36] = 1; reg_img = img;
    bus(1, 0, 0);
    send_key(0, 64);
    @(negedge clk); ext_rst_n = 0;
    @(negedge clk); ext_rst_n = 1;
    read_all(img, "R11 ignored pin");
    probe(0, "R5 forward after ignored pin");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule